// File: doc/BRIEF.md
# Interlocked Clock Source Control Register

This block is a single byte-wide control register, reached over a simple register bus, that decides which sources feed the chip's slow and fast clock trees. It controls whether the PLL is powered, and it enables two auxiliary clock prescalers. It also keeps a sticky flag that records a power-on event. The flag can only be cleared by software.

Writes do not land blindly. A filter looks at the register contents from before the write, together with a PLL-stable status input, and refuses any change that would leave the system clock on a PLL that is off or has not settled. It also refuses to power down the PLL while the PLL is still the selected fast source. The auxiliary clock enables only take effect while the main oscillator reports that it is stable. The PLL stop output can also be forced by an external power-management request.

Top module: `clksel_ctrl`

## Requirements
- R1: After synchronous reset the register reads 0x26: slow select (bit 0) = 0, fast select (bit 1) = 1, PLL power-down (bit 2) = 1, aux 1 enable (bit 3) = 0, aux 2 enable (bit 4) = 0, power-on flag (bit 5) = 1.
- R2: Bits 0, 3 and 4 take the write data on a rising clock edge only when `bus_wr` is high and `bus_addr` equals `REG_ADDR`. Otherwise the register holds its value.
- R3: Bits 7 and 6 always read 0. `bus_rdata` is 0 whenever `bus_addr` does not equal `REG_ADDR`.
- R4: A write with bit 1 = 0 clears fast select only if the PLL power-down bit was 0 before the write, the same write leaves power-down at 0, and `pll_stable` is high. Otherwise fast select stays as it was. A write with bit 1 = 1 always sets it.
- R5: A write with bit 2 = 1 sets power-down only if fast select was 1 before the write. Otherwise power-down stays 0. A write with bit 2 = 0 clears it.
- R6: A single write that clears bit 1 and sets bit 2, starting from fast = 1 and power-down = 0, gives fast = 1 and power-down = 1.
- R7: The power-on flag is cleared by a write with bit 5 = 0 and is left unchanged by a write with bit 5 = 1. A high `por_detect` sets it on the next edge, and this wins over a clearing write in the same cycle.
- R8: `auxN_clk_en` equals its enable bit AND `main_stable`.
- R9: `pll_stop` equals the power-down bit OR `pm_pll_stop`.
- R10: `slow_src_xtal` mirrors bit 0 and `fast_src_main` mirrors bit 1.
- R11: Power-down set always implies fast select set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when the address does not match |
| pll_stable | input | 1 | PLL output has settled |
| main_stable | input | 1 | Main oscillator has settled |
| por_detect | input | 1 | Power-on event pulse |
| pm_pll_stop | input | 1 | Power-management PLL stop request |
| slow_src_xtal | output | 1 | 1: slow clock from 32.768 kHz oscillator, 0: prescaled main clock |
| fast_src_main | output | 1 | 1: system clock from 12 MHz main clock, 0: from PLL |
| pll_stop | output | 1 | PLL power-down level |
| aux1_clk_en | output | 1 | Auxiliary clock 1 run enable |
| aux2_clk_en | output | 1 | Auxiliary clock 2 run enable |

## Verification
Two kinds of event can meet in one edge: a software write that clears the power-on flag and a `por_detect` pulse that sets it. In the same way, a power-down request and a PLL switch can arrive in one write and be judged against each other. The bench provokes the first by raising `por_detect` during a clearing write, both in a directed case and periodically during a sweep, and expects the flag to read 1. It provokes the second with a write of 0x24 from a fast-selected, PLL-on state and expects 0x26. In the sweep, every write value is applied under both PLL-stable levels and with matching, missing and non-strobed access, and each readback is compared with a bench model built from the requirements.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    localparam int CTL_W     = 8;
    localparam int NUM_AUX   = 2;

    // Bit positions decoded by the clock tree and the software driver
    localparam int B_SLOW    = 0;
    localparam int B_FAST    = 1;
    localparam int B_PLLOFF  = 2;
    localparam int B_AUX1    = 3;
    localparam int B_AUX2    = 4;
    localparam int B_POR     = 5;
    localparam int LIVE_W    = B_POR + 1;

    typedef struct packed {
        logic [CTL_W-LIVE_W-1:0] rsvd;
        logic                    por_seen;
        logic                    aux2_on;
        logic                    aux1_on;
        logic                    pll_off;
        logic                    fast_main;
        logic                    slow_xtal;
    } clk_ctl_t;

    localparam clk_ctl_t CTL_RESET = '{
        rsvd:      '0,
        por_seen:  1'b1,
        aux2_on:   1'b0,
        aux1_on:   1'b0,
        pll_off:   1'b1,
        fast_main: 1'b1,
        slow_xtal: 1'b0
    };

    function automatic logic [CTL_W-1:0] ctl_to_bus(input clk_ctl_t c);
        logic [CTL_W-1:0] v;
        v = '0;
        v[LIVE_W-1:0] = c[LIVE_W-1:0];
        return v;
    endfunction

endpackage

// File: rtl/clksel_wr_filter.sv
module clksel_wr_filter
    import clksel_pkg::*;
(
    input  clk_ctl_t              cur,
    input  logic [LIVE_W-1:0]     wbits,
    input  logic                  pll_stable,
    output clk_ctl_t              nxt
);

    logic pd_next;
    logic pll_switch_ok;

    // Power-down may only be raised while the main clock is the source
    assign pd_next = wbits[B_PLLOFF] & (cur.fast_main | cur.pll_off);

    // Moving onto the PLL needs it on before and after this write, and settled
    assign pll_switch_ok = ~cur.pll_off & ~pd_next & pll_stable;

    always_comb begin
        nxt           = cur;
        nxt.rsvd      = '0;
        nxt.slow_xtal = wbits[B_SLOW];
        nxt.aux1_on   = wbits[B_AUX1];
        nxt.aux2_on   = wbits[B_AUX2];
        nxt.pll_off   = pd_next;
        if (wbits[B_FAST])
            nxt.fast_main = 1'b1;
        else if (pll_switch_ok)
            nxt.fast_main = 1'b0;
        else
            nxt.fast_main = cur.fast_main;
        nxt.por_seen  = cur.por_seen & wbits[B_POR];
    end

endmodule

// File: rtl/clksel_out_drive.sv
module clksel_out_drive
    import clksel_pkg::*;
(
    input  clk_ctl_t              ctl,
    input  logic                  main_stable,
    input  logic                  pm_pll_stop,
    output logic                  slow_src_xtal,
    output logic                  fast_src_main,
    output logic                  pll_stop,
    output logic [NUM_AUX-1:0]    aux_run
);

    logic [NUM_AUX-1:0] aux_bits;

    assign aux_bits      = {ctl.aux2_on, ctl.aux1_on};
    assign slow_src_xtal = ctl.slow_xtal;
    assign fast_src_main = ctl.fast_main;
    assign pll_stop      = ctl.pll_off | pm_pll_stop;

    for (genvar g = 0; g < NUM_AUX; g++) begin : g_aux
        assign aux_run[g] = aux_bits[g] & main_stable;
    end

endmodule

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
    import clksel_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [CTL_W-1:0]  bus_wdata,
    output logic [CTL_W-1:0]  bus_rdata,
    input  logic              pll_stable,
    input  logic              main_stable,
    input  logic              por_detect,
    input  logic              pm_pll_stop,
    output logic              slow_src_xtal,
    output logic              fast_src_main,
    output logic              pll_stop,
    output logic              aux1_clk_en,
    output logic              aux2_clk_en
);

    clk_ctl_t           ctl_q;
    clk_ctl_t           ctl_wr;
    logic               hit;
    logic               wr_hit;
    logic [NUM_AUX-1:0] aux_run;
    logic               unused_rsvd_wdata;

    assign hit               = (bus_addr == REG_ADDR);
    assign wr_hit            = hit & bus_wr;
    assign unused_rsvd_wdata = ^bus_wdata[CTL_W-1:LIVE_W];

    clksel_wr_filter u_filter (
        .cur        (ctl_q),
        .wbits      (bus_wdata[LIVE_W-1:0]),
        .pll_stable (pll_stable),
        .nxt        (ctl_wr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= CTL_RESET;
        end else begin
            if (wr_hit)
                ctl_q <= ctl_wr;
            if (por_detect)
                ctl_q.por_seen <= 1'b1;
        end
    end

    assign bus_rdata = hit ? ctl_to_bus(ctl_q) : '0;

    clksel_out_drive u_out (
        .ctl           (ctl_q),
        .main_stable   (main_stable),
        .pm_pll_stop   (pm_pll_stop),
        .slow_src_xtal (slow_src_xtal),
        .fast_src_main (fast_src_main),
        .pll_stop      (pll_stop),
        .aux_run       (aux_run)
    );

    assign aux1_clk_en = aux_run[0];
    assign aux2_clk_en = aux_run[1];

    // R11: PLL off never coexists with PLL selected
    a_r11_off_implies_main: assert property (@(posedge clk) disable iff (rst)
        ctl_q.pll_off |-> ctl_q.fast_main);

    // R4: no move to the PLL while it was powered down
    a_r4_hold_main_while_off: assert property (@(posedge clk) disable iff (rst)
        ctl_q.pll_off |=> ctl_q.fast_main);

    // R4: no move to the PLL while it is unsettled
    a_r4_hold_main_unstable: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.fast_main && !pll_stable) |=> ctl_q.fast_main);

    // R5: power-down refused while the PLL drives the system clock
    a_r5_no_off_on_pll: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q.fast_main && !ctl_q.pll_off) |=> !ctl_q.pll_off);

    // R7: a power-on event always leaves the flag set
    a_r7_por_sets_flag: assert property (@(posedge clk) disable iff (rst)
        por_detect |=> ctl_q.por_seen);

    // R2: no strobed hit and no event means nothing moves
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!wr_hit && !por_detect) |=> $stable(ctl_q));

    // R3: reserved read bits stay zero
    a_r3_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[CTL_W-1:LIVE_W] == '0);

endmodule

// File: tb/clksel_ctrl_tb_top.sv
module clksel_ctrl_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam int          WATCHDOG   = 20000;
    localparam logic [7:0]  RADDR      = 8'h40;
    localparam logic [7:0]  OTHER      = 8'h41;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = RADDR;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       pll_stable = 1'b0;
    logic       main_stable = 1'b0;
    logic       por_detect = 1'b0;
    logic       pm_pll_stop = 1'b0;
    logic       slow_src_xtal, fast_src_main, pll_stop, aux1_clk_en, aux2_clk_en;

    int checks = 0;
    int errors = 0;
    logic [5:0] model;   // bit order as in the requirements
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clksel_ctrl #(.ADDR_W(8), .REG_ADDR(8'h40)) dut_i (
        .clk, .rst, .bus_addr, .bus_wr, .bus_wdata, .bus_rdata,
        .pll_stable, .main_stable, .por_detect, .pm_pll_stop,
        .slow_src_xtal, .fast_src_main, .pll_stop, .aux1_clk_en, .aux2_clk_en
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] model_next(input logic [5:0] s, input logic [7:0] wd,
                                               input logic ps, input logic hitw, input logic det);
        logic [5:0] n;
        n = s;
        if (hitw) begin
            n[0] = wd[0];
            n[3] = wd[3];
            n[4] = wd[4];
            n[2] = wd[2] ? (s[1] | s[2]) : 1'b0;
            if (wd[1])                              n[1] = 1'b1;
            else if (!s[2] && !n[2] && ps)          n[1] = 1'b0;
            n[5] = s[5] & wd[5];
        end
        if (det) n[5] = 1'b1;
        return n;
    endfunction

    // Called in the low phase; applies one cycle and checks after the next falling edge
    task automatic step(input logic [7:0] a, input logic w, input logic [7:0] wd,
                        input logic ps, input logic ms, input logic pm, input logic det);
        bus_addr = a; bus_wr = w; bus_wdata = wd;
        pll_stable = ps; main_stable = ms; pm_pll_stop = pm; por_detect = det;
        model = model_next(model, wd, ps, w && (a == RADDR), det);
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; por_detect = 1'b0;
        #1;
        if (a != RADDR) chk(bus_rdata, 8'h00, "R3 miss read");
        bus_addr = RADDR;
        #1;
        chk({2'b00, bus_rdata[5]}, {2'b00, model[5]}, "R7 por flag");
        chk({5'b0, bus_rdata[4], bus_rdata[3], bus_rdata[0]},
            {5'b0, model[4], model[3], model[0]}, "R2 plain fields");
        chk({7'b0, bus_rdata[1]}, {7'b0, model[1]}, "R4 fast select");
        chk({7'b0, bus_rdata[2]}, {7'b0, model[2]}, "R5 power-down");
        chk({6'b0, bus_rdata[7:6]}, 8'h00, "R3 reserved");
        chk({7'b0, bus_rdata[2] & ~bus_rdata[1]}, 8'h00, "R11 off implies main");
        chk({6'b0, aux2_clk_en, aux1_clk_en}, {6'b0, model[4] & ms, model[3] & ms}, "R8 aux enables");
        chk({7'b0, pll_stop}, {7'b0, model[2] | pm}, "R9 pll stop");
        chk({6'b0, fast_src_main, slow_src_xtal}, {6'b0, model[1], model[0]}, "R10 source outputs");
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(bus_rdata, 8'h26, "R1 reset value");
        chk({3'b0, aux2_clk_en, aux1_clk_en, pll_stop, fast_src_main, slow_src_xtal},
            8'h06, "R1 reset outputs");
        model = 6'h26;

        // R6 combined write: get onto main with PLL on, then clear fast + set pd
        step(RADDR, 1'b1, 8'h22, 1'b1, 1'b1, 1'b0, 1'b0);
        chk(bus_rdata, 8'h22, "R6 setup");
        step(RADDR, 1'b1, 8'h24, 1'b1, 1'b1, 1'b0, 1'b0);
        chk(bus_rdata, 8'h26, "R6 combined write");

        // R7 clear and detect in the same cycle: detect wins
        step(RADDR, 1'b1, 8'h06, 1'b1, 1'b1, 1'b0, 1'b1);
        chk(bus_rdata, 8'h26, "R7 detect beats clear");
        step(RADDR, 1'b1, 8'h06, 1'b1, 1'b1, 1'b0, 1'b0);
        chk(bus_rdata, 8'h06, "R7 software clear");
        step(RADDR, 1'b1, 8'h26, 1'b1, 1'b1, 1'b0, 1'b0);
        chk(bus_rdata, 8'h06, "R7 write one ignored");
        step(RADDR, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1);
        chk(bus_rdata, 8'h26, "R7 detect sets");

        // R4 switch to PLL, then refusal when unstable
        step(RADDR, 1'b1, 8'h22, 1'b1, 1'b1, 1'b0, 1'b0);
        step(RADDR, 1'b1, 8'h20, 1'b0, 1'b1, 1'b0, 1'b0);
        chk(bus_rdata, 8'h22, "R4 refused while unstable");
        step(RADDR, 1'b1, 8'h20, 1'b1, 1'b1, 1'b0, 1'b0);
        chk(bus_rdata, 8'h20, "R4 switch to pll");
        step(RADDR, 1'b1, 8'h24, 1'b1, 1'b1, 1'b0, 1'b0);
        chk(bus_rdata, 8'h20, "R5 power-down refused on pll");

        // Near-exhaustive sweep: PLL stable level x access kind x all write data
        for (int ps = 1; ps >= 0; ps--) begin
            for (int mode = 0; mode < 3; mode++) begin
                for (int wd = 0; wd < 256; wd++) begin
                    logic [7:0] d;
                    d = 8'(wd);
                    step(mode == 1 ? OTHER : RADDR, mode != 2, d, ps[0],
                         d[6] ^ mode[0], d[7], (wd % 11) == 5);
                end
            end
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule